// File: doc/BRIEF.md
# Function Event Force Block

This block holds the status-change events of one network controller function and drives two active-high output pins from them: an interrupt line and a general wake (status-change) line. Each event is a sticky bit. It is set by a one-cycle strobe from the hardware that detects the event, or by a host write to a force register that injects the event for debugging. The bit stays set until the host writes a 1 to that bit of the event register.

The host reaches the block through a simple register port. Writes take effect at a clock edge. Reads are combinational from the address. The port decodes three registers. The force register stores nothing: a write to it only sets event bits, and a read returns zero. The event register holds the sticky bits and clears them when a 1 is written to a bit. The mask register holds one suppress bit per pin. Each pin is driven by a two-state machine, `PIN_IDLE` or `PIN_ACTIVE`. The machine moves `PIN_IDLE -> PIN_ACTIVE` when its event bit is set and its mask bit is clear. It moves `PIN_ACTIVE -> PIN_IDLE` when the event bit clears or the mask bit sets. In all other cycles it stays in its state. The pin is high exactly in `PIN_ACTIVE`, so it lags the event and mask state by one clock.

Top module: `fn_event_force`

## Requirements
- R1: After reset, the event and mask registers are zero, both pins are low, and a read at any address returns zero.
- R2: A write to the force register (address 2) with bit 15 set sets the interrupt event bit (event register bit 15) at that clock edge. The same write with bit 4 set sets the wake event bit (event register bit 4).
- R3: Writing 0 to force bits 15 or 4, or any value to the reserved force bits (31:16, 14:5, 3:0), leaves the event register unchanged.
- R4: A read of the force register (address 2) or of the spare address 3 returns all zeros. Writes to address 3 change no register.
- R5: A one-cycle strobe on `hw_event_i[0]` sets event bit 15. A one-cycle strobe on `hw_event_i[1]` sets event bit 4.
- R6: A set event bit stays set across idle cycles and across writes of 0 to that bit of the event register (address 0).
- R7: Writing 1 to bit 15 or bit 4 of the event register clears that bit only at the clock edge. Other event bits are kept.
- R8: When a set (strobe or force) and a clear of the same event bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` equals (event bit 15 AND NOT mask bit 15) as it was one clock earlier. `wake_o` follows the same rule with event bit 4 and mask bit 4.
- R10: The mask register (address 1) stores bits 15 (interrupt suppress) and 4 (wake suppress). Its other bits read 0. A set mask bit holds its pin low and leaves the event bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 2 | Register address: 0 event, 1 mask, 2 force, 3 spare |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| hw_event_i | input | 2 | Event strobes: bit 0 interrupt source, bit 1 wake source |
| irq_o | output | 1 | Interrupt pin, registered, active high |
| wake_o | output | 1 | Wake/status-change pin, registered, active high |

## Verification
The assertions assume that the write strobe and the event strobes are sampled cleanly at the rising edge and that reset is held long enough for every register to settle. A set and a clear may coincide, and the set-wins property covers that case. The bench changes every input only at falling edges and holds each strobe for exactly one cycle. It sweeps all force patterns against all mask patterns, with and without the reserved bits set, and so never creates a case outside these assumptions.

// File: rtl/fn_event_force_pkg.sv
package fn_event_force_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 2;
    localparam int NUM_EV   = 2;
    localparam int INT_BIT  = 15;
    localparam int WAKE_BIT = 4;

    // Bit position of each event in the force, event and mask registers
    localparam int EV_POS [NUM_EV] = '{INT_BIT, WAKE_BIT};

    typedef enum logic [ADDR_W-1:0] {
        A_EVENT = 2'd0,
        A_MASK  = 2'd1,
        A_FORCE = 2'd2,
        A_SPARE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        PIN_IDLE   = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

endpackage

// File: rtl/fn_event_regport.sv
module fn_event_regport
    import fn_event_force_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = ADDR_W,
    parameter int NE = NUM_EV
) (
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    input  logic [NE-1:0] ev_q_i,
    input  logic [NE-1:0] mask_q_i,
    output logic [NE-1:0] force_set_o,
    output logic [NE-1:0] clr_o,
    output logic          mask_we_o,
    output logic [NE-1:0] mask_d_o,
    output logic [DW-1:0] reg_rdata_o
);

    reg_addr_e addr;
    logic      unused_wdata;

    assign addr         = reg_addr_e'(reg_addr_i);
    assign unused_wdata = ^reg_wdata_i;

    // Write decode: only the mapped bit positions act
    always_comb begin
        for (int i = 0; i < NE; i++) begin
            force_set_o[i] = reg_wr_i && (addr == A_FORCE) && reg_wdata_i[EV_POS[i]];
            clr_o[i]       = reg_wr_i && (addr == A_EVENT) && reg_wdata_i[EV_POS[i]];
            mask_d_o[i]    = reg_wdata_i[EV_POS[i]];
        end
        mask_we_o = reg_wr_i && (addr == A_MASK);
    end

    // Read mux: the force register holds no state
    always_comb begin
        reg_rdata_o = '0;
        unique case (addr)
            A_EVENT: for (int i = 0; i < NE; i++) reg_rdata_o[EV_POS[i]] = ev_q_i[i];
            A_MASK:  for (int i = 0; i < NE; i++) reg_rdata_o[EV_POS[i]] = mask_q_i[i];
            A_FORCE: reg_rdata_o = '0;
            A_SPARE: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/fn_event_bank.sv
module fn_event_bank
    import fn_event_force_pkg::*;
#(
    parameter int NE = NUM_EV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] force_set_i,
    input  logic [NE-1:0] hw_event_i,
    input  logic [NE-1:0] clr_i,
    input  logic          mask_we_i,
    input  logic [NE-1:0] mask_d_i,
    output logic [NE-1:0] ev_q_o,
    output logic [NE-1:0] mask_q_o
);

    logic [NE-1:0] set_req;
    assign set_req = force_set_i | hw_event_i;

    for (genvar i = 0; i < NE; i++) begin : g_ev
        // Sticky bit: set has priority over write-one-to-clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            ev_q_o[i] <= 1'b0;
            else if (set_req[i])   ev_q_o[i] <= 1'b1;
            else if (clr_i[i])     ev_q_o[i] <= 1'b0;
        end

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> ev_q_o[i]);
        // R6
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_q_o[i] && !clr_i[i]) |=> ev_q_o[i]);
        // R7
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_req[i]) |=> !ev_q_o[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q_o <= '0;
        else if (mask_we_i) mask_q_o <= mask_d_i;
    end

endmodule

// File: rtl/fn_event_pin_fsm.sv
module fn_event_pin_fsm
    import fn_event_force_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic mask_i,
    output logic pin_o
);

    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE:   if (ev_i && !mask_i)  state_d = PIN_ACTIVE;
            PIN_ACTIVE: if (!ev_i || mask_i)  state_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pin_o = (state_q == PIN_ACTIVE);
    end

    // R9
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_o == $past(ev_i && !mask_i)));
    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !pin_o);

endmodule

// File: rtl/fn_event_force.sv
module fn_event_force
    import fn_event_force_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [NUM_EV-1:0] hw_event_i,
    output logic              irq_o,
    output logic              wake_o
);

    logic [NUM_EV-1:0] force_set, clr, mask_d, ev_q, mask_q, pins;
    logic              mask_we;

    fn_event_regport #(.DW(REG_W), .AW(ADDR_W), .NE(NUM_EV)) u_port (
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .ev_q_i      (ev_q),
        .mask_q_i    (mask_q),
        .force_set_o (force_set),
        .clr_o       (clr),
        .mask_we_o   (mask_we),
        .mask_d_o    (mask_d),
        .reg_rdata_o (reg_rdata_o)
    );

    fn_event_bank #(.NE(NUM_EV)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_set_i (force_set),
        .hw_event_i  (hw_event_i),
        .clr_i       (clr),
        .mask_we_i   (mask_we),
        .mask_d_i    (mask_d),
        .ev_q_o      (ev_q),
        .mask_q_o    (mask_q)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_pin
        fn_event_pin_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_i   (ev_q[i]),
            .mask_i (mask_q[i]),
            .pin_o  (pins[i])
        );
    end

    assign irq_o  = pins[0];
    assign wake_o = pins[1];

endmodule

// File: tb/fn_event_force_test.sv
`timescale 1ns/1ps
module fn_event_force_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  hw_event = 2'b00;
    logic        irq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] RES = 32'hFFFF_7FEF;

    always #2 clk = ~clk;

    fn_event_force uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hw_event_i(hw_event),
        .irq_o(irq), .wake_o(wake)
    );

    function automatic logic [31:0] spread(input logic [1:0] b);
        spread = (32'(b[0]) << 15) | (32'(b[1]) << 4);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic strobe(input logic [1:0] h);
        @(negedge clk);
        hw_event = h;
        @(negedge clk);
        hw_event = 2'b00;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) rd_check("R1 reset read", 2'(a), 32'h0);
        check("R1 reset pins", {30'h0, wake, irq}, 32'h0);

        // R2 / R9 latency: event bit first, pin one edge later
        wr(2'd2, 32'h0000_8000);
        rd_check("R2 force int", 2'd0, 32'h0000_8000);
        check("R9 pin lag", {31'h0, irq}, 32'h0);
        idle();
        check("R9 pin high", {31'h0, irq}, 32'h1);
        wr(2'd0, 32'hFFFF_FFFF);

        // R2 / R3 / R4 force sweep with and without reserved bits
        for (int f = 0; f < 4; f++) begin
            for (int r = 0; r < 2; r++) begin
                wr(2'd0, 32'hFFFF_FFFF);
                wr(2'd2, spread(2'(f)) | (r == 1 ? RES : 32'h0));
                rd_check("R2 R3 force sweep event", 2'd0, spread(2'(f)));
                rd_check("R4 force reads zero", 2'd2, 32'h0);
                idle();
                check("R9 sweep pins", {30'h0, wake, irq}, 32'(f));
            end
        end

        // R10 mask sweep
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 4; e++) begin
                wr(2'd0, 32'hFFFF_FFFF);
                wr(2'd1, spread(2'(m)) | RES);
                rd_check("R10 mask read", 2'd1, spread(2'(m)));
                wr(2'd2, spread(2'(e)));
                idle();
                check("R10 masked pins", {30'h0, wake, irq}, 32'(e & ~m & 3));
                rd_check("R10 event kept", 2'd0, spread(2'(e)));
            end
        end
        wr(2'd1, 32'h0);

        // R6 / R7 sticky and write-one-to-clear
        wr(2'd2, 32'h0000_8010);
        wr(2'd0, 32'h0);
        rd_check("R6 write zero keeps", 2'd0, 32'h0000_8010);
        wr(2'd0, 32'h0000_8000);
        rd_check("R7 clear int only", 2'd0, 32'h0000_0010);
        repeat (5) idle();
        rd_check("R6 sticky idle", 2'd0, 32'h0000_0010);
        idle();
        check("R9 pins after clear", {30'h0, wake, irq}, 32'h2);

        // R5 hardware strobes
        for (int h = 1; h < 4; h++) begin
            wr(2'd0, 32'hFFFF_FFFF);
            strobe(2'(h));
            rd_check("R5 strobe", 2'd0, spread(2'(h)));
        end

        // R8 set wins against clear in the same cycle
        wr(2'd2, 32'h0000_8010);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1; hw_event = 2'b01;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; hw_event = 2'b00;
        rd_check("R8 set wins", 2'd0, 32'h0000_8000);

        // R4 spare address ignored
        wr(2'd3, 32'hFFFF_FFFF);
        rd_check("R4 spare read", 2'd3, 32'h0);
        rd_check("R4 spare event", 2'd0, 32'h0000_8000);
        rd_check("R4 spare mask", 2'd1, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule